// File: doc/BRIEF.md
# Load/store-multiple micro-op sequencer

This block turns one block-transfer instruction into a stream of micro-operations. A start pulse, taken only while the block is idle, captures a register-selection mask together with four control bits: direction (up), pre-index, load and writeback. It also captures the base register number. The block then issues its micro-ops one at a time through a valid/ready handshake.

The first micro-op copies the base register into a temporary register. Every memory micro-op that follows addresses relative to that temporary copy. Next comes one load or store per selected register, in ascending register order. Each of these carries the register number and an unsigned byte offset. When writeback is requested, a final add-immediate or subtract-immediate micro-op adjusts the base register by the total transfer size.

The controller is a four-state machine. IDLE waits for start and goes to COPY. COPY issues the copy micro-op. When it is accepted, the machine goes to XFER if any register is selected, otherwise to WBACK if writeback is requested, otherwise back to IDLE. XFER issues one memory micro-op per handshake and clears the lowest remaining mask bit each time. After the last register it goes to WBACK or IDLE. WBACK issues the base update and returns to IDLE once it is accepted.

Top module: `lsm_uop_seq`

## Requirements
- R1: After reset, `idle` is 1 and `uop_valid` is 0.
- R2: A start pulse while idle makes the next cycle present a copy micro-op: kind code 0, `uop_reg` equal to the captured base register, offset 0.
- R3: After the copy, exactly one memory micro-op is issued per set bit of the captured mask, in ascending register number, with `uop_reg` giving that register number.
- R4: A memory micro-op has kind code 1 (load) when the load bit was set, and kind code 2 (store) otherwise.
- R5: The first memory offset is 0 when up is set and 4·N−4 when up is clear, where N is the number of set mask bits. Pre-index adds 4 in either case.
- R6: Each following memory offset is the previous one plus 4 when up is set, or minus 4 when up is clear.
- R7: With writeback, the final micro-op names the base register, has offset 4·N, and has kind code 3 (add) when up is set or kind code 4 (subtract) when up is clear.
- R8: `uop_last` is 1 on the final micro-op of the sequence and 0 on every other one. This includes an empty mask, where the copy is final unless writeback adds one more micro-op.
- R9: While `uop_valid` is 1 and `uop_ready` is 0, the valid signal and all micro-op fields stay unchanged into the next cycle.
- R10: A start pulse, or any change of the mask or control inputs, while a sequence is in flight has no effect on the micro-ops issued.
- R11: A sequence consists of 1 + N + (writeback ? 1 : 0) micro-ops. In the cycle after the last one is accepted, `idle` is 1 and `uop_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence; taken only when idle |
| reg_list | input | LIST_W (16) | Register-selection mask, bit i selects register i |
| up | input | 1 | Ascending addresses when 1, descending when 0 |
| pre | input | 1 | Pre-index: shift the offsets by one word |
| load | input | 1 | Load when 1, store when 0 |
| wb | input | 1 | Append a base-register update |
| base_reg | input | IDX_W (4) | Base register number |
| idle | output | 1 | Ready to accept start |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer accepts the micro-op |
| uop_kind | output | 3 | 0 copy, 1 load, 2 store, 3 add-imm, 4 sub-imm |
| uop_reg | output | IDX_W (4) | Register field |
| uop_ofs | output | OFS_W (8) | Unsigned offset or immediate magnitude |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
The bench builds the block with its default parameters: a 16-bit mask, an 8-bit offset field and a 4-byte word step. These values let a full mask reach register 15 and the largest offset and writeback immediate of 64, with pre-index in both directions. Directed cases cover the empty mask with and without writeback, a single register, sparse and full masks in each direction, stalls on ready, and a start pulse issued during a running sequence.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [2:0] {
        UOP_COPY  = 3'd0,
        UOP_LOAD  = 3'd1,
        UOP_STORE = 3'd2,
        UOP_ADDI  = 3'd3,
        UOP_SUBI  = 3'd4
    } uop_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COPY  = 2'd1,
        ST_XFER  = 2'd2,
        ST_WBACK = 2'd3
    } seq_state_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_in,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
#(
    parameter int LIST_W = 16,
    parameter int OFS_W  = 8,
    parameter int STEP   = 4,
    localparam int IDX_W = $clog2(LIST_W),
    localparam int CNT_W = $clog2(LIST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LIST_W-1:0] reg_list,
    input  logic              up,
    input  logic              pre,
    input  logic              load,
    input  logic              wb,
    input  logic [IDX_W-1:0]  base_reg,
    output logic              idle,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [2:0]        uop_kind,
    output logic [IDX_W-1:0]  uop_reg,
    output logic [OFS_W-1:0]  uop_ofs,
    output logic              uop_last
);
    localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);

    seq_state_e        state_q, state_d;
    logic [LIST_W-1:0] rem_q;
    logic              up_q, load_q, wb_q;
    logic [IDX_W-1:0]  base_q;
    logic [OFS_W-1:0]  ofs_q, span_q;

    logic [CNT_W-1:0]  sel_cnt;
    logic [IDX_W-1:0]  low_idx;
    logic [LIST_W-1:0] rem_next;
    logic [OFS_W-1:0]  span_in, start_ofs;
    logic              fire;

    lsm_popcount #(.W(LIST_W)) u_cnt (
        .bits_in (reg_list),
        .count   (sel_cnt)
    );

    lsm_lowbit #(.W(LIST_W)) u_low (
        .vec (rem_q),
        .idx (low_idx)
    );

    assign rem_next  = rem_q & (rem_q - LIST_W'(1));
    assign span_in   = OFS_W'(sel_cnt) * STEP_V;
    assign start_ofs = (up ? '0 : span_in - STEP_V) + (pre ? STEP_V : '0);
    assign fire      = uop_valid && uop_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_COPY;
            ST_COPY:  if (fire) state_d = (rem_q != '0) ? ST_XFER :
                                          (wb_q ? ST_WBACK : ST_IDLE);
            ST_XFER:  if (fire && rem_next == '0)
                          state_d = wb_q ? ST_WBACK : ST_IDLE;
            ST_WBACK: if (fire) state_d = ST_IDLE;
        endcase
    end

    // Captured instruction and walking offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            up_q   <= 1'b0;
            load_q <= 1'b0;
            wb_q   <= 1'b0;
            base_q <= '0;
            ofs_q  <= '0;
            span_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            rem_q  <= reg_list;
            up_q   <= up;
            load_q <= load;
            wb_q   <= wb;
            base_q <= base_reg;
            ofs_q  <= start_ofs;
            span_q <= span_in;
        end else if (state_q == ST_XFER && fire) begin
            rem_q  <= rem_next;
            ofs_q  <= up_q ? ofs_q + STEP_V : ofs_q - STEP_V;
        end
    end

    // Outputs
    always_comb begin
        idle      = 1'b0;
        uop_valid = 1'b1;
        uop_kind  = UOP_COPY;
        uop_reg   = base_q;
        uop_ofs   = '0;
        uop_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle      = 1'b1;
                uop_valid = 1'b0;
            end
            ST_COPY: begin
                uop_last = (rem_q == '0) && !wb_q;
            end
            ST_XFER: begin
                uop_kind = load_q ? UOP_LOAD : UOP_STORE;
                uop_reg  = low_idx;
                uop_ofs  = ofs_q;
                uop_last = (rem_next == '0) && !wb_q;
            end
            ST_WBACK: begin
                uop_kind = up_q ? UOP_ADDI : UOP_SUBI;
                uop_ofs  = span_q;
                uop_last = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
    parameter int IDX_W = 4,
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             idle,
    input logic             uop_valid,
    input logic             uop_ready,
    input logic [2:0]       uop_kind,
    input logic [IDX_W-1:0] uop_reg,
    input logic [OFS_W-1:0] uop_ofs,
    input logic             uop_last
);
    logic is_mem;
    assign is_mem = (uop_kind == 3'd1) || (uop_kind == 3'd2);

    p_copy_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && idle |=> uop_valid && uop_kind == 3'd0 && uop_ofs == '0);

    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && is_mem |=>
            !(uop_valid && is_mem) || (uop_reg > $past(uop_reg)));

    p_wback_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && (uop_kind == 3'd3 || uop_kind == 3'd4) |-> uop_last);

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) &&
            $stable(uop_reg) && $stable(uop_ofs) && $stable(uop_last));

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && uop_last |=> idle && !uop_valid);

    p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> uop_kind <= 3'd4);
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .idle      (idle),
    .uop_valid (uop_valid),
    .uop_ready (uop_ready),
    .uop_kind  (uop_kind),
    .uop_reg   (uop_reg),
    .uop_ofs   (uop_ofs),
    .uop_last  (uop_last)
);

// File: tb/lsm_uop_seq_test.sv
module lsm_uop_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] reg_list = '0;
    logic        up = 1'b0, pre = 1'b0, load = 1'b0, wb = 1'b0;
    logic [3:0]  base_reg = '0;
    logic        idle, uop_valid;
    logic        uop_ready = 1'b0;
    logic [2:0]  uop_kind;
    logic [3:0]  uop_reg;
    logic [7:0]  uop_ofs;
    logic        uop_last;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lsm_uop_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
        .up(up), .pre(pre), .load(load), .wb(wb), .base_reg(base_reg),
        .idle(idle), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_kind(uop_kind), .uop_reg(uop_reg), .uop_ofs(uop_ofs),
        .uop_last(uop_last)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Present-uop snapshot: valid, kind, reg, offset, last
    function automatic logic [31:0] cur();
        return {15'd0, uop_valid, uop_kind, uop_reg, uop_ofs, uop_last};
    endfunction

    // Called at a negedge with a micro-op expected on the outputs
    task automatic take(input string tag, input logic [2:0] k, input logic [3:0] r,
                        input logic [7:0] o, input logic l, input bit stall);
        logic [31:0] snap;
        if (stall) begin
            uop_ready = 1'b0;
            snap = cur();
            @(negedge clk);
            chk("R9 hold under stall", cur(), snap);
        end
        uop_ready = 1'b1;
        chk(tag, cur(), {15'd0, 1'b1, k, r, o, l});
        @(negedge clk);
        uop_ready = 1'b0;
    endtask

    task automatic run_seq(input logic [15:0] lst, input bit u, input bit p,
                           input bit l, input bit w, input logic [3:0] b,
                           input bit stall, input bit poke);
        int n = $countones(lst);
        int left = n;
        logic [7:0] ofs;
        @(negedge clk);
        reg_list = lst; up = u; pre = p; load = l; wb = w; base_reg = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1; reg_list = ~lst; up = ~u; pre = ~p;
            load = ~l; wb = ~w; base_reg = ~b;
        end
        ofs = (u ? 8'd0 : 8'(n * 4 - 4)) + (p ? 8'd4 : 8'd0);
        take(poke ? "R10 R2 copy after busy start" : "R2 R8 copy", 3'd0, b, 8'd0,
             (n == 0) && !w, stall);
        start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                left--;
                take(poke ? "R10 R3 R4 R5 R6 memory op" : "R3 R4 R5 R6 R8 memory op",
                     l ? 3'd1 : 3'd2, 4'(i), ofs, (left == 0) && !w, stall);
                ofs = u ? ofs + 8'd4 : ofs - 8'd4;
            end
        end
        if (w) take("R7 R8 writeback", u ? 3'd3 : 3'd4, b, 8'(n * 4), 1'b1, stall);
        chk("R11 idle after last", {30'd0, idle, uop_valid}, 32'd2);
    endtask

    task automatic t_reset();
        chk("R1 reset idle/valid", {30'd0, idle, uop_valid}, 32'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset release", {30'd0, idle, uop_valid}, 32'd2);
    endtask

    task automatic t_up_post_load();   run_seq(16'h0095, 1, 0, 1, 0, 4'd13, 0, 0); endtask
    task automatic t_up_pre_store_wb(); run_seq(16'h8421, 1, 1, 0, 1, 4'd2, 0, 0); endtask
    task automatic t_down_post_wb();   run_seq(16'h0306, 0, 0, 1, 1, 4'd7, 0, 0); endtask
    task automatic t_down_pre_store(); run_seq(16'h0c10, 0, 1, 0, 0, 4'd0, 0, 0); endtask
    task automatic t_empty_nowb();     run_seq(16'h0000, 1, 0, 1, 0, 4'd5, 0, 0); endtask
    task automatic t_empty_wb();       run_seq(16'h0000, 0, 1, 0, 1, 4'd9, 0, 0); endtask
    task automatic t_single();         run_seq(16'h4000, 0, 0, 1, 0, 4'd3, 0, 0); endtask
    task automatic t_full_down_pre();  run_seq(16'hffff, 0, 1, 1, 1, 4'd15, 0, 0); endtask
    task automatic t_full_up_pre();    run_seq(16'hffff, 1, 1, 0, 1, 4'd1, 0, 0); endtask
    task automatic t_stall();          run_seq(16'h1248, 0, 0, 0, 1, 4'd6, 1, 0); endtask
    task automatic t_busy_start();     run_seq(16'h0a05, 1, 0, 1, 1, 4'd11, 0, 1); endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_up_post_load();
        t_up_pre_store_wb();
        t_down_post_wb();
        t_down_pre_store();
        t_empty_nowb();
        t_empty_wb();
        t_single();
        t_full_down_pre();
        t_full_up_pre();
        t_stall();
        t_busy_start();
        @(negedge clk);
        chk("R10 R11 stays idle", {30'd0, idle, uop_valid}, 32'd2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule